// File: doc/BRIEF.md
# Lane-Parallel Grouped Matrix-Vector Engine

This block forms the product of a small signed 8-bit weight matrix (ROWS by COLS) and a signed 8-bit activation vector of length COLS. The host fills local storage through a single write port, pulses `start`, and then receives one result per row on a valid-qualified stream, followed by a one-cycle `done` pulse. The activation vector stays in local storage and is reused by every row and by later runs. Before a row is computed, all of its weights are copied into a local row buffer.

LANES multiply-accumulate lanes work side by side. Each lane owns one slot of an accumulation vector, so a row takes COLS/LANES multiply steps. A separate reduction phase then folds the lane slots together, one lane per cycle. In plain mode the whole row is one group, and the folded sum is the row result. In grouped mode each run of GROUP consecutive columns has its own signed 16-bit fixed-point scale with 8 fractional bits. The lane slots are folded at every group end, multiplied by that group's scale, shifted right arithmetically by 8, and added to the row total. The lanes are then cleared for the next group.

Top module: `lane_matvec`

## Requirements
- R1: After reset, `out_valid` and `done` are low.
- R2: With `qmode`=0 at start, each row result equals the exact signed dot product of the row's weights and the activations, where operands are wr_data[7:0] read as two's complement.
- R3: With `qmode`=1 at start, each row result is the sum over its groups of (G·s) >>> 8. G is the signed dot product over the group's GROUP columns. s is the group's scale, taken as the 16-bit two's-complement wr_data. The shift is arithmetic, so it rounds toward minus infinity.
- R4: A run emits exactly ROWS results in ascending row order, each marked by one `out_valid` cycle, and never asserts `out_valid` and `done` in the same cycle.
- R5: `done` is high for exactly one cycle, in the cycle immediately after the last row's `out_valid`.
- R6: A `start` pulse that arrives while a run is in progress has no effect: the run keeps its results, and no further results appear afterwards.
- R7: Activations written once remain valid for any number of later runs, including runs whose weights have been rewritten.
- R8: With the start pulse sampled at clock edge 0, row r's result is valid after edge (r+1)·P. P is 2·COLS/LANES+LANES+1 in plain mode and COLS/LANES+(COLS/GROUP)·(GROUP/LANES+LANES+1) in grouped mode. Lane slots are cleared before every row and every group.
- R9: LANES and GROUP are powers of two, GROUP is a multiple of LANES, and COLS is a multiple of GROUP.
- R10: Operands of +127 or -128 everywhere, and scales of 32767 or -32768, give exact results with no wrap-around.
- R11: Write select codes: 0 writes activation[addr], 1 writes weight at addr = row·COLS+col, 2 writes scale at addr = row·(COLS/GROUP)+group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for local storage |
| wr_sel | input | 2 | Target: 0 activation, 1 weight, 2 scale |
| wr_addr | input | ADDR_W | Element address within the selected target |
| wr_data | input | 16 | Operand in bits 7:0, or a 16-bit scale |
| start | input | 1 | Begins a run when the engine is idle |
| qmode | input | 1 | Grouped scaling mode, sampled at start |
| out_valid | output | 1 | One-cycle marker for a row result |
| out_data | output | 48 | Signed row result |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions take it that storage is written only while the engine is idle, and that `qmode` matters only in the cycle that `start` is accepted. They also take it that every write address lies inside its target's range. The stimulus issues all writes before pulsing `start` and after `done` has been observed. The only input it toggles during a run is a deliberate stray `start`. Addresses come from loops bounded by the configured row, column and group counts. The sweeps cover random matrices in both modes and every extreme operand and scale pairing. A rerun with the activations held and only the weights rewritten checks R7.

// File: rtl/lmv_pkg.sv
package lmv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_MAC    = 3'd2,
        ST_REDUCE = 3'd3,
        ST_SCALE  = 3'd4,
        ST_FIN    = 3'd5
    } mv_state_e;

    localparam logic [1:0] SEL_ACT = 2'd0;
    localparam logic [1:0] SEL_WT  = 2'd1;
    localparam logic [1:0] SEL_SCL = 2'd2;
endpackage

// File: rtl/lmv_lane.sv
module lmv_lane #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [AW-1:0] acc
);
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   acc_d, acc_q;

    assign prod = a * b;

    always_comb begin
        acc_d = acc_q;
        if (clr)
            acc_d = '0;
        else if (en)
            acc_d = acc_q + AW'(prod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // clearing and accumulating never overlap (R8)
    assert_clr_excl_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && en));
endmodule

// File: rtl/lmv_store.sv
module lmv_store
    import lmv_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SW    = 16,
    parameter int LANES = 4,
    parameter int GROUP = 8,
    parameter int COLS  = 16,
    parameter int ROWS  = 4,
    localparam int NGRP   = COLS / GROUP,
    localparam int STEPS  = COLS / LANES,
    localparam int ADDR_W = $clog2(ROWS * COLS),
    localparam int COL_W  = $clog2(COLS),
    localparam int SC_W   = (ROWS * NGRP > 1) ? $clog2(ROWS * NGRP) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [SW-1:0]               wr_data,
    input  logic [ROW_W-1:0]            rd_row,
    input  logic [STEP_W-1:0]           rd_step,
    input  logic [GRP_W-1:0]            rd_grp,
    output logic [LANES-1:0][DW-1:0]    wt_chunk,
    output logic [LANES-1:0][DW-1:0]    act_chunk,
    output logic [SW-1:0]               scale
);
    logic [DW-1:0] act_q [COLS];
    logic [DW-1:0] wt_q  [ROWS*COLS];
    logic [SW-1:0] sc_q  [ROWS*NGRP];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (wr_sel)
                SEL_ACT: if (int'(wr_addr) < COLS)
                    act_q[COL_W'(wr_addr)] <= wr_data[DW-1:0];
                SEL_WT:  if (int'(wr_addr) < ROWS * COLS)
                    wt_q[wr_addr] <= wr_data[DW-1:0];
                SEL_SCL: if (int'(wr_addr) < ROWS * NGRP)
                    sc_q[SC_W'(wr_addr)] <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        assign wt_chunk[i]  = wt_q[ADDR_W'(int'(rd_row) * COLS + int'(rd_step) * LANES + i)];
        assign act_chunk[i] = act_q[COL_W'(int'(rd_step) * LANES + i)];
    end

    assign scale = sc_q[SC_W'(int'(rd_row) * NGRP + int'(rd_grp))];
endmodule

// File: rtl/lane_matvec.sv
module lane_matvec
    import lmv_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SW    = 16,
    parameter int FRAC  = 8,
    parameter int LACC  = 32,
    parameter int RW    = 48,
    parameter int LANES = 4,
    parameter int GROUP = 8,
    parameter int COLS  = 16,
    parameter int ROWS  = 4,
    localparam int NGRP   = COLS / GROUP,
    localparam int STEPS  = COLS / LANES,
    localparam int GSTEPS = GROUP / LANES,
    localparam int ADDR_W = $clog2(ROWS * COLS),
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1,
    localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SW-1:0]     wr_data,
    input  logic              start,
    input  logic              qmode,
    output logic              out_valid,
    output logic [RW-1:0]     out_data,
    output logic              done
);
    typedef struct packed {
        mv_state_e          st;
        logic [ROW_W-1:0]   row;
        logic [STEP_W-1:0]  step;
        logic [STEP_W-1:0]  gcnt;
        logic [GRP_W-1:0]   grp;
        logic [LANE_W-1:0]  lane;
        logic signed [RW-1:0] red;
        logic signed [RW-1:0] acc;
        logic               qm;
        logic               vld;
        logic               fin;
        logic [RW-1:0]      res;
    } eng_t;

    eng_t s_d, s_q;

    logic [LANES-1:0][DW-1:0] wt_chunk, act_chunk, w_op;
    logic [SW-1:0]            sc_rd;
    logic signed [LACC-1:0]   lane_acc [LANES];
    logic [DW-1:0]            rowbuf_q [COLS];
    logic                     lane_clr, lane_en, rb_we, busy, last_grp;
    logic [STEP_W-1:0]        glen_m1;
    logic signed [RW-1:0]     scl_ext, scl_prod, scaled, total;

    lmv_store #(.DW(DW), .SW(SW), .LANES(LANES), .GROUP(GROUP), .COLS(COLS), .ROWS(ROWS)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_row(s_q.row), .rd_step(s_q.step), .rd_grp(s_q.grp),
        .wt_chunk(wt_chunk), .act_chunk(act_chunk), .scale(sc_rd)
    );

    // row buffer: filled chunk by chunk during the fetch phase
    always_ff @(posedge clk) begin
        if (rb_we)
            for (int i = 0; i < LANES; i++)
                rowbuf_q[COL_W'(int'(s_q.step) * LANES + i)] <= wt_chunk[i];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign w_op[i] = rowbuf_q[COL_W'(int'(s_q.step) * LANES + i)];
        lmv_lane #(.DW(DW), .AW(LACC)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(lane_clr), .en(lane_en),
            .a($signed(w_op[i])), .b($signed(act_chunk[i])), .acc(lane_acc[i])
        );
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign glen_m1  = s_q.qm ? STEP_W'(GSTEPS - 1) : STEP_W'(STEPS - 1);
    assign last_grp = !s_q.qm || (s_q.grp == GRP_W'(NGRP - 1));
    assign scl_ext  = RW'($signed(sc_rd));
    assign scl_prod = s_q.red * scl_ext;
    assign scaled   = scl_prod >>> FRAC;
    assign total    = s_q.acc + (s_q.qm ? scaled : s_q.red);

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.fin  = 1'b0;
        lane_clr = 1'b0;
        lane_en  = 1'b0;
        rb_we    = 1'b0;
        case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.st   = ST_FETCH;
                s_d.row  = '0;
                s_d.step = '0;
                s_d.qm   = qmode;
            end
            ST_FETCH: begin
                rb_we    = 1'b1;
                lane_clr = 1'b1;
                s_d.acc  = '0;
                s_d.grp  = '0;
                s_d.gcnt = '0;
                if (s_q.step == STEP_W'(STEPS - 1)) begin
                    s_d.step = '0;
                    s_d.st   = ST_MAC;
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
            ST_MAC: begin
                lane_en  = 1'b1;
                s_d.step = s_q.step + 1'b1;
                if (s_q.gcnt == glen_m1) begin
                    s_d.gcnt = '0;
                    s_d.lane = '0;
                    s_d.red  = '0;
                    s_d.st   = ST_REDUCE;
                end else begin
                    s_d.gcnt = s_q.gcnt + 1'b1;
                end
            end
            ST_REDUCE: begin
                s_d.red = s_q.red + RW'(lane_acc[s_q.lane]);
                if (s_q.lane == LANE_W'(LANES - 1)) s_d.st = ST_SCALE;
                else                                s_d.lane = s_q.lane + 1'b1;
            end
            ST_SCALE: begin
                lane_clr = 1'b1;
                s_d.acc  = total;
                if (last_grp) begin
                    s_d.vld = 1'b1;
                    s_d.res = total;
                    if (s_q.row == ROW_W'(ROWS - 1)) begin
                        s_d.st = ST_FIN;
                    end else begin
                        s_d.row  = s_q.row + 1'b1;
                        s_d.step = '0;
                        s_d.st   = ST_FETCH;
                    end
                end else begin
                    s_d.grp = s_q.grp + 1'b1;
                    s_d.st  = ST_MAC;
                end
            end
            ST_FIN: begin
                s_d.fin = 1'b1;
                s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_data  = s_q.res;
    assign done      = s_q.fin;

    assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    assert_valid_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, done}));
    assert_done_after_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid));
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && s_q.st != ST_FIN) |=> busy);
endmodule

// File: tb/sim_lane_matvec.sv
module sim_lane_matvec;
    localparam int LANES = 4, GROUP = 8, COLS = 16, ROWS = 4;
    localparam int NGRP = COLS / GROUP, STEPS = COLS / LANES, GSTEPS = GROUP / LANES;
    localparam int ADDR_W = $clog2(ROWS * COLS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, start = 1'b0, qmode = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic out_valid, done;
    logic [47:0] out_data;

    always #10 clk = ~clk;

    lane_matvec #(.LANES(LANES), .GROUP(GROUP), .COLS(COLS), .ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .qmode(qmode),
        .out_valid(out_valid), .out_data(out_data), .done(done)
    );

    int checks = 0, errors = 0, cyc = 0;
    int wm [ROWS][COLS];
    int xv [COLS];
    int sc [ROWS][NGRP];
    longint expv [ROWS];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = ADDR_W'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input bit acts);
        if (acts) for (int c = 0; c < COLS; c++) wr(2'd0, c, xv[c]);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) wr(2'd1, r * COLS + c, wm[r][c]);
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < NGRP; g++) wr(2'd2, r * NGRP + g, sc[r][g]);
    endtask

    function automatic void model(input bit q);
        for (int r = 0; r < ROWS; r++) begin
            expv[r] = 0;
            for (int g = 0; g < NGRP; g++) begin
                longint gs = 0;
                for (int c = g * GROUP; c < (g + 1) * GROUP; c++) gs += longint'(wm[r][c]) * xv[c];
                expv[r] += q ? ((gs * sc[r][g]) >>> 8) : gs;
            end
        end
    endfunction

    function automatic void fill(input int wmode, input int xmode, input int smode);
        for (int c = 0; c < COLS; c++)
            xv[c] = (xmode == 0) ? $urandom_range(0, 255) - 128 : xmode;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++)
                wm[r][c] = (wmode == 0) ? $urandom_range(0, 255) - 128 : wmode;
            for (int g = 0; g < NGRP; g++)
                sc[r][g] = (smode == 0) ? $urandom_range(0, 65535) - 32768 : smode;
        end
    endfunction

    // one run; results compared against the model, row timing per R8
    task automatic run(input bit q, input bit poke, input string tag);
        int t = 0, last = 0, nres = 0, period;
        bit fin = 1'b0;
        period = q ? STEPS + NGRP * (GSTEPS + LANES + 1) : 2 * STEPS + LANES + 1;
        model(q);
        @(negedge clk); start = 1'b1; qmode = q;
        @(negedge clk); start = 1'b0; qmode = 1'b0;
        while (!fin && t < 500) begin
            @(negedge clk);
            t++;
            start = (poke && t == 5);
            if (out_valid) begin
                chk(nres < ROWS, "R4 too many rows", nres + 1, ROWS);
                if (nres < ROWS)
                    chk($signed(out_data) == expv[nres], q ? {"R3 ", tag} : {"R2 ", tag},
                        $signed(out_data), expv[nres]);
                chk(t - last == period, "R8 row interval", t - last, period);
                last = t;
                nres++;
            end
            if (done) begin
                chk(t == last + 1, "R5 done after last valid", t, last + 1);
                chk(nres == ROWS, "R4 row count", nres, ROWS);
                fin = 1'b1;
            end
        end
        start = 1'b0;
        chk(fin, "R5 done seen", fin, 1);
        if (poke) begin
            int extra = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (out_valid || done) extra++;
            end
            chk(extra == 0, "R6 stray start ignored", extra, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 reset outputs", {out_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 after release", {out_valid, done}, 0);

        // R9: configuration constraints
        chk((LANES & (LANES - 1)) == 0 && (GROUP & (GROUP - 1)) == 0, "R9 powers of two", LANES, GROUP);
        chk(GROUP % LANES == 0 && COLS % GROUP == 0, "R9 multiples", COLS % GROUP, 0);

        // R2/R3 random sweeps, R11 write encodings
        for (int k = 0; k < 3; k++) begin
            fill(0, 0, 0); load(1'b1); run(1'b0, 1'b0, "random R11");
            fill(0, 0, 0); load(1'b1); run(1'b1, 1'b0, "random R11");
        end

        // R10: extreme operands and scales
        fill(127, 127, 32767);    load(1'b1); run(1'b0, 1'b0, "R10 max");   run(1'b1, 1'b0, "R10 max");
        fill(-128, -128, -32768); load(1'b1); run(1'b0, 1'b0, "R10 min");   run(1'b1, 1'b0, "R10 min");
        fill(127, -128, 32767);   load(1'b1); run(1'b0, 1'b0, "R10 mixed"); run(1'b1, 1'b0, "R10 mixed");
        fill(-128, -128, 32767);  load(1'b1); run(1'b1, 1'b0, "R10 max scale");
        fill(-128, 127, -32768);  load(1'b1); run(1'b1, 1'b0, "R10 neg scale");

        // R7: activations kept, only weights and scales rewritten
        fill(0, 0, 0); load(1'b1); run(1'b1, 1'b0, "R7 first");
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) wm[r][c] = $urandom_range(0, 255) - 128;
        load(1'b0); run(1'b1, 1'b0, "R7 reuse"); run(1'b0, 1'b0, "R7 reuse");

        // R6: stray start during a run
        fill(0, 0, 0); load(1'b1); run(1'b0, 1'b1, "R6 run");
        run(1'b1, 1'b1, "R6 run");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule